// File: doc/BRIEF.md
# Relocatable Memory-Map Address Decoder

This block turns the 16-bit address from the CPU of a small 8-bit microcontroller into one-hot select lines. The targets are on-chip RAM, a 64-byte block of control registers, on-chip EEPROM, on-chip EPROM and the external bus. When no target claims an address, a final line marks it as unmapped. When RAM is selected, the block also outputs the byte offset into the RAM array.

An 8-bit map register places the RAM window and the register window. Each can sit on any 4 KB boundary, and the two are set independently. The upper nibble of the map register gives the RAM base page, and the lower nibble gives the register page. The map register can be written only during a short window after reset.

Two enable inputs take the EPROM and the EEPROM out of the map. A two-bit mode input controls two things: whether unclaimed addresses go to the external bus, and whether interrupt vector fetches are steered into RAM. Steering vectors into RAM lets a loaded program service interrupts through a jump table held there.

Top module: `memmap_decoder`

## Requirements
- R1: After reset the map register holds 8'h01. The RAM window therefore starts at $0000 and the register window at $1000.
- R2: A write to the map register that is accepted moves the RAM window to page `map_wdata[7:4]` ($x000) and the register window to page `map_wdata[3:0]`. The two pages are independent.
- R3: A write is taken only on one of the first 64 rising clock edges after reset is released. On those edges an internal counter reads 0 to 63. Writes on later edges leave the map unchanged.
- R4: The RAM window covers 768 bytes from its base. A hit drives `sel_ram` and sets `ram_addr` to `addr[9:0]`. The byte at base+$300 is outside the window.
- R5: The register window covers 64 bytes from its base. Where it overlaps RAM, `sel_reg` wins, so the first 64 RAM bytes cannot be reached.
- R6: When `nvm_en` is 1, addresses $B600 to $B7FF select the EEPROM (`sel_nvm`). Inside that range it takes priority over the EPROM.
- R7: When `rom_en` is 1, addresses $B000 to $FFFF that are not claimed by a window or by the EEPROM select the EPROM (`sel_rom`). When `rom_en` is 0, the EPROM is never selected.
- R8: An address claimed by nothing drives `sel_ext` when `mode[0]` is 1 (expanded) and `sel_none` when `mode[0]` is 0. On-chip decoding is the same in both cases.
- R9: When `mode[1]` is 1 (bootstrap), `vec_fetch` is 1 and the address is $FFC0 or higher, the decoder selects RAM with `ram_addr` = 704 + `addr[5:0]`. This overrides every other target.
- R10: Exactly one of the six select outputs is 1 for every input combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address |
| vec_fetch | input | 1 | Current access is an interrupt vector fetch |
| mode | input | 2 | bit0 = external bus enabled, bit1 = bootstrap vector steering |
| rom_en | input | 1 | EPROM present in the map |
| nvm_en | input | 1 | EEPROM present in the map |
| map_we | input | 1 | Map register write strobe |
| map_wdata | input | 8 | Map register write data |
| sel_reg | output | 1 | Register block selected |
| sel_ram | output | 1 | RAM selected |
| sel_nvm | output | 1 | EEPROM selected |
| sel_rom | output | 1 | EPROM selected |
| sel_ext | output | 1 | External bus selected |
| sel_none | output | 1 | Address unmapped |
| ram_addr | output | 10 | Byte offset into RAM |

## Verification
The only state in the block is the map register and its write-window counter. A wrong map value appears as soon as the next address is decoded: the RAM hits and register hits land on the wrong 4 KB pages. A counter that stops early or late shows up as a write accepted or refused exactly at the 64th edge. The bench therefore probes the window edges, the RAM end at offset 767 and 768, and the register end at offset 63 and 64, directly after each map change. The decode itself is combinational, so any priority or enable error shows up in the same cycle as the address that exposes it.

// File: rtl/memmap_decoder.sv
module memmap_decoder #(
  parameter int          AW          = 16,
  parameter int          RAM_BYTES   = 768,
  parameter int          REG_BYTES   = 64,
  parameter int          WIN_CYCLES  = 64,
  parameter logic [7:0]  MAP_RESET   = 8'h01,
  parameter logic [15:0] NVM_LO      = 16'hB600,
  parameter logic [15:0] NVM_HI      = 16'hB7FF,
  parameter logic [15:0] ROM_LO      = 16'hB000,
  parameter logic [15:0] ROM_HI      = 16'hFFFF,
  parameter logic [15:0] VEC_LO      = 16'hFFC0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          vec_fetch,
  input  logic [1:0]    mode,
  input  logic          rom_en,
  input  logic          nvm_en,
  input  logic          map_we,
  input  logic [7:0]    map_wdata,
  output logic          sel_reg,
  output logic          sel_ram,
  output logic          sel_nvm,
  output logic          sel_rom,
  output logic          sel_ext,
  output logic          sel_none,
  output logic [9:0]    ram_addr
);
  localparam int CW      = $clog2(WIN_CYCLES + 1);
  localparam int PAGE_LO = AW - 4;
  localparam int VEC_SZ  = (1 << AW) - int'(VEC_LO);
  localparam int VEC_OFS = RAM_BYTES - VEC_SZ;

  logic [7:0]    map_q;
  logic [CW-1:0] cnt_q;
  logic          win_open;

  assign win_open = (cnt_q < CW'(WIN_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= MAP_RESET;
      cnt_q <= '0;
    end else begin
      if (win_open) cnt_q <= cnt_q + 1'b1;
      if (map_we && win_open) map_q <= map_wdata;
    end
  end

  logic [PAGE_LO-1:0] page_off;
  logic hit_vec, hit_reg, hit_ram, hit_nvm, hit_rom;

  assign page_off = addr[PAGE_LO-1:0];
  assign hit_vec  = mode[1] && vec_fetch && (addr >= VEC_LO);
  assign hit_reg  = (addr[AW-1:PAGE_LO] == map_q[3:0]) && (int'(page_off) < REG_BYTES);
  assign hit_ram  = (addr[AW-1:PAGE_LO] == map_q[7:4]) && (int'(page_off) < RAM_BYTES);
  assign hit_nvm  = nvm_en && (addr >= NVM_LO) && (addr <= NVM_HI);
  assign hit_rom  = rom_en && (addr >= ROM_LO) && (addr <= ROM_HI);

  always_comb begin
    {sel_reg, sel_ram, sel_nvm, sel_rom, sel_ext, sel_none} = '0;
    ram_addr = addr[9:0];
    if (hit_vec) begin
      sel_ram  = 1'b1;
      ram_addr = 10'(VEC_OFS) + 10'(addr[5:0]);
    end else if (hit_reg)  sel_reg  = 1'b1;
    else if (hit_ram)      sel_ram  = 1'b1;
    else if (hit_nvm)      sel_nvm  = 1'b1;
    else if (hit_rom)      sel_rom  = 1'b1;
    else if (mode[0])      sel_ext  = 1'b1;
    else                   sel_none = 1'b1;
  end

  // R3
  map_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(map_q));
  // R2
  map_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_we && win_open) |=> (map_q == $past(map_wdata)));
  // R10
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_reg, sel_ram, sel_nvm, sel_rom, sel_ext, sel_none}) == 1);
  // R7
  rom_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_en |-> !sel_rom);
  // R8
  no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[0] |-> !sel_ext);
  // R6
  nvm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nvm_en |-> !sel_nvm);
endmodule

// File: tb/memmap_decoder_bench.sv
module memmap_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        vec_fetch = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        rom_en = 1'b1, nvm_en = 1'b1;
  logic        map_we = 1'b0;
  logic [7:0]  map_wdata = '0;
  logic        sel_reg, sel_ram, sel_nvm, sel_rom, sel_ext, sel_none;
  logic [9:0]  ram_addr;

  int tests = 0, fails = 0;
  logic [7:0] map_m;
  logic done = 1'b0;

  always #2 clk = ~clk;

  memmap_decoder u_memmap_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .vec_fetch(vec_fetch), .mode(mode),
    .rom_en(rom_en), .nvm_en(nvm_en), .map_we(map_we), .map_wdata(map_wdata),
    .sel_reg(sel_reg), .sel_ram(sel_ram), .sel_nvm(sel_nvm), .sel_rom(sel_rom),
    .sel_ext(sel_ext), .sel_none(sel_none), .ram_addr(ram_addr));

  function automatic logic [15:0] model(input logic [15:0] a, input logic vf,
      input logic [1:0] md, input logic re, input logic ne, input logic [7:0] m);
    logic [5:0] s;
    logic [9:0] ra;
    s = '0; ra = a[9:0];
    if (md[1] && vf && a >= 16'hFFC0) begin s = 6'b010000; ra = 10'd704 + 10'(a[5:0]); end
    else if (a[15:12] == m[3:0] && a[11:0] < 12'd64)  s = 6'b100000;
    else if (a[15:12] == m[7:4] && a[11:0] < 12'd768) s = 6'b010000;
    else if (ne && a >= 16'hB600 && a <= 16'hB7FF)    s = 6'b001000;
    else if (re && a >= 16'hB000)                     s = 6'b000100;
    else if (md[0])                                   s = 6'b000010;
    else                                              s = 6'b000001;
    return {s, ra};
  endfunction

  task automatic probe(input logic [15:0] a, input logic vf, input logic [1:0] md,
      input logic re, input logic ne, input string req);
    logic [15:0] e;
    logic [5:0]  got;
    @(negedge clk);
    addr = a; vec_fetch = vf; mode = md; rom_en = re; nvm_en = ne;
    #1;
    e = model(a, vf, md, re, ne, map_m);
    got = {sel_reg, sel_ram, sel_nvm, sel_rom, sel_ext, sel_none};
    tests++;
    if (got != e[15:10] || (e[14] && ram_addr != e[9:0])) begin
      fails++;
      $display("FAIL %s addr=%h map=%h sel=%b ram_addr=%0d expected sel=%b ram_addr=%0d",
               req, a, map_m, got, ram_addr, e[15:10], e[9:0]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; map_we = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    map_m = 8'h01;
  endtask

  task automatic write_after(input int edges_before, input logic [7:0] d, input logic accept);
    repeat (edges_before) @(posedge clk);
    @(negedge clk); map_we = 1'b1; map_wdata = d;
    @(negedge clk); map_we = 1'b0;
    if (accept) map_m = d;
  endtask

  task automatic probe_edges(input string req);
    probe({map_m[7:4], 12'h000}, 1'b0, 2'b00, 1'b1, 1'b1, req);
    probe({map_m[7:4], 12'h2FF}, 1'b0, 2'b00, 1'b1, 1'b1, req);
    probe({map_m[7:4], 12'h300}, 1'b0, 2'b01, 1'b1, 1'b1, req);
    probe({map_m[3:0], 12'h03F}, 1'b0, 2'b00, 1'b1, 1'b1, req);
    probe({map_m[3:0], 12'h040}, 1'b0, 2'b01, 1'b1, 1'b1, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    do_reset();
    // R1 reset placement
    probe(16'h0000, 1'b0, 2'b00, 1'b1, 1'b1, "R1");
    probe(16'h1000, 1'b0, 2'b00, 1'b1, 1'b1, "R1");
    probe(16'h02FF, 1'b0, 2'b00, 1'b1, 1'b1, "R4");
    probe(16'h0300, 1'b0, 2'b00, 1'b1, 1'b1, "R4");
    probe(16'h1040, 1'b0, 2'b01, 1'b1, 1'b1, "R5");
    // R6 R7 EEPROM over EPROM and enables
    probe(16'hB600, 1'b0, 2'b00, 1'b1, 1'b1, "R6");
    probe(16'hB7FF, 1'b0, 2'b00, 1'b1, 1'b1, "R6");
    probe(16'hB600, 1'b0, 2'b01, 1'b1, 1'b0, "R6");
    probe(16'hB000, 1'b0, 2'b00, 1'b1, 1'b1, "R7");
    probe(16'hC000, 1'b0, 2'b01, 1'b0, 1'b1, "R7");
    probe(16'h8000, 1'b0, 2'b00, 1'b1, 1'b1, "R8");
    probe(16'h8000, 1'b0, 2'b01, 1'b1, 1'b1, "R8");
    // R9 vector steering
    probe(16'hFFFE, 1'b1, 2'b10, 1'b1, 1'b1, "R9");
    probe(16'hFFC0, 1'b1, 2'b11, 1'b1, 1'b1, "R9");
    probe(16'hFFBF, 1'b1, 2'b10, 1'b1, 1'b1, "R9");
    probe(16'hFFFE, 1'b0, 2'b10, 1'b1, 1'b1, "R9");
    probe(16'hFFFE, 1'b1, 2'b01, 1'b1, 1'b1, "R9");

    // R5 shared page: registers win
    do_reset();
    write_after(0, 8'h33, 1'b1);
    probe(16'h3000, 1'b0, 2'b00, 1'b1, 1'b1, "R5");
    probe(16'h303F, 1'b0, 2'b00, 1'b1, 1'b1, "R5");
    probe(16'h3040, 1'b0, 2'b00, 1'b1, 1'b1, "R5");

    // R3 window edge: edge with count 63 accepted
    do_reset();
    write_after(63, 8'h7A, 1'b1);
    probe_edges("R3");
    // R3 edge with count 64 rejected
    do_reset();
    write_after(64, 8'h5C, 1'b0);
    probe_edges("R3");
    probe(16'h1000, 1'b0, 2'b00, 1'b1, 1'b1, "R3");
    // R3 much later write ignored after an accepted one
    do_reset();
    write_after(2, 8'hE4, 1'b1);
    write_after(80, 8'h21, 1'b0);
    probe_edges("R3");

    // R2 R10 random maps and random decode
    void'($urandom(32'd1234));
    for (int k = 0; k < 40; k++) begin
      do_reset();
      write_after($urandom_range(0, 40), 8'($urandom), 1'b1);
      probe_edges("R2");
      for (int j = 0; j < 120; j++) begin
        logic [15:0] a;
        a = 16'($urandom);
        if (j % 4 == 0) a = {map_m[7:4], 12'($urandom_range(0, 800))};
        if (j % 4 == 1) a = {map_m[3:0], 12'($urandom_range(0, 80))};
        probe(a, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), "R10");
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule